// File: doc/BRIEF.md
# Pedestrian Crossing Signal Sequencer

This block drives the red and green elements of an RGB crossing indicator at a trail crossing. While nobody waits, it holds a steady green. A request on any of its push-button lines starts a fixed three-part sequence: a flashing-red phase, a solid-red phase and a second flashing-red phase. After that it returns to green and waits for the next request. All timing comes from an external periodic half-second tick strobe. Each phase length is a parameter counted in ticks: 12 ticks for each flashing phase and 8 ticks for the solid phase by default.

The button lines are asynchronous. Each line passes through a two-flop synchroniser, and only a rising edge counts as a request, so a button held down makes one request. A new request during the first flashing phase restarts that phase from its beginning. In the solid phase and in the second flashing phase, requests have no effect. The tick strobe is a single-clock pulse from a separate timer.

Top module: `xing_signal_seq`

## Requirements
- R1: While idle, green_o is 1 and red_o is 0, and tick pulses do not change the outputs.
- R2: A 0-to-1 transition on any bit of btn_i while idle is seen after three rising clock edges (two synchroniser flops plus the state register). The block then enters the first flashing phase with red_o = 1 and green_o = 0.
- R3: In either flashing phase, after k ticks counted from the start of the phase, red_o is 1 for even k and 0 for odd k. Red is on first and toggles on every tick.
- R4: The first flashing phase ends on its FLASH_TICKS-th tick (default 12), and red_o then stays at 1 in the solid phase.
- R5: The solid phase lasts exactly SOLID_TICKS ticks (default 8). It is followed by the second flashing phase, which starts with red_o = 1.
- R6: The second flashing phase ends on its FLASH_TICKS-th tick. The block then shows green again and accepts new requests.
- R7: A new request during the first flashing phase sets its tick count back to zero with red_o = 1. A full FLASH_TICKS ticks must then pass before the solid phase starts.
- R8: Requests during the solid phase or the second flashing phase change neither the phase nor its tick count.
- R9: A button held high makes only one request. After the sequence ends, the block stays green until that button is released and pressed again.
- R10: Asserting rst_n low puts the block into idle green at once, without waiting for a clock edge, with every counter cleared. Release takes effect on the clock edge.
- R11: red_o and green_o are never both 1, and green_o is 1 only in the idle phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | NUM_BTN | Asynchronous push-button request lines, active high |
| tick_i | input | 1 | Half-second strobe, one clock cycle wide |
| red_o | output | 1 | Red element drive of the indicator |
| green_o | output | 1 | Green element drive of the indicator |

## Verification
The bench restarts the first flashing phase after every possible number of elapsed ticks. A design that fails to clear the count, or that clears only the blink, would reach the solid phase early or show red out of step. It presses buttons in the middle of the solid phase and the second flashing phase. A design that lets those presses reset a count would stretch a phase, and the outputs would be wrong on the tick after the expected transition. A button held for the whole sequence must not start a second sequence, which catches level-triggered detection. Each button line is swept on its own and all lines are pressed together, which catches a design that drops a bit.

// File: rtl/xing_pkg.sv
package xing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_FLASH_A = 2'd1,
    PH_SOLID   = 2'd2,
    PH_FLASH_B = 2'd3
  } phase_e;
endpackage

// File: rtl/xing_rst_sync.sv
module xing_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xing_btn_edge.sv
module xing_btn_edge #(
  parameter int NUM_BTN     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BTN-1:0] btn_i,
  output logic               press_o
);
  logic [NUM_BTN-1:0] rise;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i[b]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign rise[b] = sync_q[SYNC_STAGES-1] & ~prev_q;
  end

  assign press_o = |rise;
endmodule

// File: rtl/xing_phase_fsm.sv
module xing_phase_fsm
  import xing_pkg::*;
#(
  parameter int FLASH_TICKS = 12,
  parameter int SOLID_TICKS = 8,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             press_i,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             red_o,
  output logic             green_o
);
  localparam logic [CNT_W-1:0] FLASH_LAST = CNT_W'(FLASH_TICKS - 1);
  localparam logic [CNT_W-1:0] SOLID_LAST = CNT_W'(SOLID_TICKS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (press_i) begin
          phase_d = PH_FLASH_A;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      PH_FLASH_A: begin
        if (press_i) begin
          cnt_en = 1'b1;
          cnt_d  = '0;
        end else if (tick_i) begin
          cnt_en = 1'b1;
          if (cnt_q == FLASH_LAST) begin
            phase_d = PH_SOLID;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_SOLID: begin
        if (tick_i) begin
          cnt_en = 1'b1;
          if (cnt_q == SOLID_LAST) begin
            phase_d = PH_FLASH_B;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_FLASH_B: begin
        if (tick_i) begin
          cnt_en = 1'b1;
          if (cnt_q == FLASH_LAST) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_en  = 1'b1;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    green_o = (phase_q == PH_IDLE);
    unique case (phase_q)
      PH_SOLID:               red_o = 1'b1;
      PH_FLASH_A, PH_FLASH_B: red_o = ~cnt_q[0];
      default:                red_o = 1'b0;
    endcase
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/xing_signal_seq.sv
module xing_signal_seq
  import xing_pkg::*;
#(
  parameter int NUM_BTN     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FLASH_TICKS = 12,
  parameter int SOLID_TICKS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BTN-1:0] btn_i,
  input  logic               tick_i,
  output logic               red_o,
  output logic               green_o
);
  localparam int MAX_TICKS = (FLASH_TICKS > SOLID_TICKS) ? FLASH_TICKS : SOLID_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             rst_sync_n;
  logic             press;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;

  xing_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xing_btn_edge #(.NUM_BTN(NUM_BTN), .SYNC_STAGES(SYNC_STAGES)) i_btn_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .btn_i   (btn_i),
    .press_o (press)
  );

  xing_phase_fsm #(
    .FLASH_TICKS (FLASH_TICKS),
    .SOLID_TICKS (SOLID_TICKS),
    .CNT_W       (CNT_W)
  ) i_phase_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .press_i (press),
    .tick_i  (tick_i),
    .phase_o (phase),
    .cnt_o   (cnt),
    .red_o   (red_o),
    .green_o (green_o)
  );
endmodule

// File: rtl/xing_signal_seq_chk.sv
module xing_signal_seq_chk
  import xing_pkg::*;
#(
  parameter int FLASH_TICKS = 12,
  parameter int SOLID_TICKS = 8,
  parameter int CNT_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             press,
  input logic             tick_i,
  input phase_e           phase,
  input logic [CNT_W-1:0] cnt,
  input logic             red_o,
  input logic             green_o
);
  localparam logic [CNT_W-1:0] FLASH_LAST = CNT_W'(FLASH_TICKS - 1);

  // R11: the two colours are exclusive
  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(red_o && green_o));

  // R1: idle green holds without a request, ticks or not
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (green_o && !press) |=> (green_o && !red_o));

  // R2: a request while idle starts flashing with red lit
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (green_o && press) |=> (red_o && !green_o && phase == PH_FLASH_A));

  // R3: red toggles on every tick inside a flashing phase
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_FLASH_A || phase == PH_FLASH_B) && tick_i && !press
     && cnt != FLASH_LAST) |=> (red_o != $past(red_o)));

  // R4: a flashing count never reaches its phase length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FLASH_A || phase == PH_FLASH_B) |-> (cnt < CNT_W'(FLASH_TICKS)));

  // R7: a request in the first flashing phase restarts it
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FLASH_A && press) |=> (phase == PH_FLASH_A && cnt == '0 && red_o));

  // R8: without a tick the solid phase and its count stand still, presses or not
  p_solid_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SOLID && !tick_i) |=> (phase == PH_SOLID && $stable(cnt)));

  // R8: presses in the second flashing phase leave its count alone
  p_flash_b_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FLASH_B && !tick_i) |=> (phase == PH_FLASH_B && $stable(cnt)));
endmodule

bind xing_signal_seq xing_signal_seq_chk #(
  .FLASH_TICKS (FLASH_TICKS),
  .SOLID_TICKS (SOLID_TICKS),
  .CNT_W       (CNT_W)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .press   (press),
  .tick_i  (tick_i),
  .phase   (phase),
  .cnt     (cnt),
  .red_o   (red_o),
  .green_o (green_o)
);

// File: tb/test_xing_signal_seq.sv
`timescale 1ns/1ps
module test_xing_signal_seq;
  localparam int NB = 3;
  localparam int FL = 12;
  localparam int SL = 8;

  logic          clk;
  logic          rst_n;
  logic [NB-1:0] btn;
  logic          tick;
  logic          red;
  logic          grn;

  int n_tests;
  int n_fail;
  bit done;

  xing_signal_seq #(
    .NUM_BTN     (NB),
    .SYNC_STAGES (2),
    .FLASH_TICKS (FL),
    .SOLID_TICKS (SL)
  ) i_xing_signal_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_i   (btn),
    .tick_i  (tick),
    .red_o   (red),
    .green_o (grn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic er, input logic eg);
    n_tests++;
    if (red !== er || grn !== eg) begin
      n_fail++;
      $display("FAIL %s: red=%b green=%b expected red=%b green=%b", tag, red, grn, er, eg);
    end
  endtask

  // one-cycle tick; returns at a falling edge after the sampling edge
  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // raise the lines in m; after three rising edges the request is registered
  task automatic push(input logic [NB-1:0] m, input bit hold);
    btn = btn | m;
    repeat (3) @(negedge clk);
    if (!hold) btn = btn & ~m;
  endtask

  task automatic flash_from(input string tag, input int k0);
    for (int k = k0 + 1; k < FL; k++) begin
      pulse_tick();
      chk(tag, (k % 2) == 0, 1'b0);
    end
  endtask

  // from the last tick of the first flashing phase back to idle
  task automatic solid_and_back(input string tag);
    pulse_tick();
    chk({tag, " R4 solid entry"}, 1'b1, 1'b0);
    for (int k = 1; k < SL; k++) begin
      pulse_tick();
      chk({tag, " R5 solid"}, 1'b1, 1'b0);
    end
    pulse_tick();
    chk({tag, " R5 second flash entry"}, 1'b1, 1'b0);
    flash_from({tag, " R3 second flash"}, 0);
    pulse_tick();
    chk({tag, " R6 back to idle"}, 1'b0, 1'b1);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    btn     = '0;
    tick    = 1'b0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 in reset", 1'b0, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 after release", 1'b0, 1'b1);

    // R1: ticks in idle do nothing
    for (int i = 0; i < 3; i++) begin
      pulse_tick();
      chk("R1 idle tick", 1'b0, 1'b1);
    end

    // R2..R6: full sequence from each line on its own
    for (int b = 0; b < NB; b++) begin
      push(NB'(1) << b, 1'b0);
      chk("R2 entry", 1'b1, 1'b0);
      flash_from("R3 first flash", 0);
      solid_and_back("sweep");
    end

    // all lines at once make a single request
    push('1, 1'b0);
    chk("R2 all lines", 1'b1, 1'b0);
    flash_from("R3 all lines", 0);
    solid_and_back("all");

    // R7: restart after every possible tick count
    for (int j = 1; j < FL; j++) begin
      push(NB'(1), 1'b0);
      for (int k = 1; k <= j; k++) begin
        pulse_tick();
        chk("R7 before restart", (k % 2) == 0, 1'b0);
      end
      push(NB'(2), 1'b0);
      chk("R7 restart red on", 1'b1, 1'b0);
      flash_from("R7 after restart", 0);
      solid_and_back("R7");
    end

    // R8: presses during the solid phase and the second flashing phase
    push(NB'(1), 1'b0);
    flash_from("R3", 0);
    pulse_tick();
    chk("R8 solid entry", 1'b1, 1'b0);
    for (int k = 1; k <= 3; k++) pulse_tick();
    push(NB'(4), 1'b0);
    chk("R8 press in solid", 1'b1, 1'b0);
    for (int k = 4; k < SL; k++) begin
      pulse_tick();
      chk("R8 solid", 1'b1, 1'b0);
    end
    pulse_tick();
    chk("R8 second flash on time", 1'b1, 1'b0);
    pulse_tick();
    chk("R8 second flash k=1", 1'b0, 1'b0);
    for (int k = 2; k <= 5; k++) pulse_tick();
    push(NB'(1), 1'b0);
    chk("R8 press in second flash", 1'b0, 1'b0);
    flash_from("R8 second flash", 5);
    pulse_tick();
    chk("R8 idle on time", 1'b0, 1'b1);

    // R9: held line gives one request only
    push(NB'(2), 1'b1);
    chk("R9 held entry", 1'b1, 1'b0);
    flash_from("R9", 0);
    solid_and_back("R9");
    for (int i = 0; i < 4; i++) begin
      pulse_tick();
      chk("R9 held stays idle", 1'b0, 1'b1);
    end
    btn = '0;
    repeat (4) @(negedge clk);
    chk("R9 release no request", 1'b0, 1'b1);
    push(NB'(2), 1'b0);
    chk("R9 new press accepted", 1'b1, 1'b0);

    // R10: reset in the middle of the solid phase
    flash_from("R3", 0);
    pulse_tick();
    for (int k = 1; k <= 2; k++) pulse_tick();
    chk("R10 pre-reset solid", 1'b1, 1'b0);
    #3 rst_n = 1'b0;
    #2 chk("R10 immediate idle", 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pulse_tick();
    chk("R10 idle after reset", 1'b0, 1'b1);
    push(NB'(1), 1'b0);
    chk("R10 fresh start", 1'b1, 1'b0);
    flash_from("R10 count cleared", 0);
    solid_and_back("R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule